// File: doc/BRIEF.md
# Settable BCD Time-of-Day Clock

The block keeps the time of day in binary-coded decimal and shows hours and minutes on a four-digit, time-multiplexed seven-segment display. A divider running from the fast system clock produces a half-second toggle. That toggle drives a seconds LED with a one-hertz square wave and steps a hidden seconds counter once per second. The seconds counter feeds a cascade of decimal digit counters: minute ones, then minute tens, then a two-digit hour field that runs from 00 to 23.

Three push-button inputs set the time. Each button advances only its own field: minute ones, minute tens or hours. The field wraps within its own range and never carries into the next field. Each button is synchronized and edge-detected inside the block, so one press gives one step no matter how long the button is held. A second divider, independent of the one-second divider, paces a scanner that lights one digit at a time. Both divider lengths are parameters. The defaults suit a 100 MHz clock: a half-second count of 50,000,000 and a digit dwell of 100,000 cycles, which is about 1 kHz per digit.

Top module: `tod_clock`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the display shows 00:00 and secLed is 0.
- R2: secLed changes state once every SEC_HALF_COUNT clock cycles and holds its value between those changes.
- R3: Seconds count from 0 to 59 and advance once every 2*SEC_HALF_COUNT cycles, on the cycle in which secLed changes from 1 to 0. When the seconds roll over from 59, the minute-ones digit advances.
- R4: When a carry arrives with minute ones at 9, minute ones goes to 0 and minute tens advances (for example 00:09 becomes 00:10).
- R5: When a carry arrives with minutes at 59, the minutes go to 00 and the hours advance (for example 00:59 becomes 01:00).
- R6: When a carry arrives at 23:59, the time goes to 00:00.
- R7: A press of btnMinOnes adds one to minute ones. At 9 the digit wraps to 0 and minute tens is unchanged.
- R8: A press of btnMinTens adds one to minute tens. At 5 the digit wraps to 0 and the hours are unchanged.
- R9: A press of btnHour adds one to the hour field, which runs 00 to 23. At 23 it wraps to 00 and the minutes are unchanged.
- R10: Each button passes through a two-flip-flop synchronizer and a rising-edge detector. One press gives exactly one increment, however long the button is held.
- R11: Exactly one bit of anodeN is low at any time, and the lit digit changes every SCAN_COUNT cycles. anodeN[3] selects hour tens, anodeN[2] hour ones, anodeN[1] minute tens and anodeN[0] minute ones.
- R12: segN[6:0] carries segments g,f,e,d,c,b,a and is active low. The patterns for digits 0 to 9 are 40,79,24,30,19,12,02,78,00,10 in hex.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btnMinOnes | input | 1 | Set button for minute ones (asynchronous) |
| btnMinTens | input | 1 | Set button for minute tens (asynchronous) |
| btnHour | input | 1 | Set button for hours (asynchronous) |
| anodeN | output | 4 | Digit select, active low, one digit at a time |
| segN | output | 7 | Segment pattern g..a, active low |
| secLed | output | 1 | One-hertz seconds indicator |

## Verification
The bench reads the time back from the display scan alone, so a wrong digit order or a wrong segment table would show up as a garbled time. It checks the wrap of each set button: minute ones at 9, minute tens at 5, and hours at 23 and at 24 presses. If a set button carried into the next field, the hours or tens would change when they should hold. A long-held press is checked to give exactly one increment; an edge detector that was missing or misplaced would add many. The bench also lets time run through the natural carries at :09, :59 and 23:59. A cascade that compared against the wrong terminal value would land on times such as 00:0A, 00:60 or 24:00.

// File: rtl/tod_pkg.sv
package tod_pkg;

  typedef struct packed {
    logic secTick;
    logic setMinOnes;
    logic setMinTens;
    logic setHour;
  } todStrobes_t;

  function automatic logic [6:0] segPattern(input logic [3:0] digit);
    case (digit)
      4'd0:    segPattern = 7'h40;
      4'd1:    segPattern = 7'h79;
      4'd2:    segPattern = 7'h24;
      4'd3:    segPattern = 7'h30;
      4'd4:    segPattern = 7'h19;
      4'd5:    segPattern = 7'h12;
      4'd6:    segPattern = 7'h02;
      4'd7:    segPattern = 7'h78;
      4'd8:    segPattern = 7'h00;
      4'd9:    segPattern = 7'h10;
      default: segPattern = 7'h7F;
    endcase
  endfunction

endpackage

// File: rtl/tod_control.sv
module tod_control
  import tod_pkg::*;
#(
  parameter int SEC_HALF_COUNT = 50_000_000,
  parameter int SCAN_COUNT     = 100_000,
  parameter int NUM_BTN        = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BTN-1:0] btnRaw,
  output todStrobes_t        strobes,
  output logic [1:0]         digitSel,
  output logic               secLed
);

  localparam int SEC_W = (SEC_HALF_COUNT > 1) ? $clog2(SEC_HALF_COUNT) : 1;
  localparam int SCAN_W = (SCAN_COUNT > 1) ? $clog2(SCAN_COUNT) : 1;
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_HALF_COUNT - 1);
  localparam logic [SCAN_W-1:0] SCAN_LAST = SCAN_W'(SCAN_COUNT - 1);

  logic [SEC_W-1:0]  secCnt;
  logic [SCAN_W-1:0] scanCnt;
  logic              secWrap;
  logic              scanWrap;
  logic [NUM_BTN-1:0] pressEdge;

  assign secWrap  = (secCnt == SEC_LAST);
  assign scanWrap = (scanCnt == SCAN_LAST);

  // Half-second divider with toggled LED output
  always_ff @(posedge clk) begin
    if (rst) begin
      secCnt <= '0;
      secLed <= 1'b0;
    end else if (secWrap) begin
      secCnt <= '0;
      secLed <= ~secLed;
    end else begin
      secCnt <= secCnt + 1'b1;
    end
  end

  // Independent scan divider and digit index
  always_ff @(posedge clk) begin
    if (rst) begin
      scanCnt  <= '0;
      digitSel <= 2'd0;
    end else if (scanWrap) begin
      scanCnt  <= '0;
      digitSel <= digitSel + 2'd1;
    end else begin
      scanCnt <= scanCnt + 1'b1;
    end
  end

  // Per-button synchronizer and rising-edge detector
  for (genvar i = 0; i < NUM_BTN; i++) begin : g_btn
    logic syncA;
    logic syncB;
    logic lastB;
    always_ff @(posedge clk) begin
      if (rst) begin
        syncA <= 1'b0;
        syncB <= 1'b0;
        lastB <= 1'b0;
      end else begin
        syncA <= btnRaw[i];
        syncB <= syncA;
        lastB <= syncB;
      end
    end
    assign pressEdge[i] = syncB & ~lastB;
  end

  assign strobes.secTick    = secWrap & secLed;
  assign strobes.setMinOnes = pressEdge[0];
  assign strobes.setMinTens = pressEdge[1];
  assign strobes.setHour    = pressEdge[2];

  p_led_steady_r2: assert property (@(posedge clk) disable iff (rst)
    (secCnt != SEC_LAST) |=> $stable(secLed));

  p_led_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    secWrap |=> (secLed != $past(secLed)));

  p_single_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    strobes.setMinOnes |=> !strobes.setMinOnes);

  p_scan_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !scanWrap |=> $stable(digitSel));

endmodule

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  todStrobes_t strobes,
  input  logic [1:0]  digitSel,
  output logic [3:0]  anodeN,
  output logic [6:0]  segN
);

  logic [5:0] secCount;
  logic [3:0] minOnes;
  logic [3:0] minTens;
  logic [3:0] hourOnes;
  logic [3:0] hourTens;

  logic secCarry;
  logic minOnesInc;
  logic minOnesCarry;
  logic minTensInc;
  logic minTensCarry;
  logic hourInc;
  logic hourAtTop;
  logic [3:0] shownDigit;

  assign secCarry     = strobes.secTick && (secCount == 6'd59);
  assign minOnesInc   = secCarry || strobes.setMinOnes;
  assign minOnesCarry = secCarry && (minOnes == 4'd9);
  assign minTensInc   = minOnesCarry || strobes.setMinTens;
  assign minTensCarry = minOnesCarry && (minTens == 4'd5);
  assign hourInc      = minTensCarry || strobes.setHour;
  assign hourAtTop    = (hourTens == 4'd2) && (hourOnes == 4'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      secCount <= 6'd0;
    end else if (strobes.secTick) begin
      secCount <= (secCount == 6'd59) ? 6'd0 : secCount + 6'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      minOnes <= 4'd0;
    end else if (minOnesInc) begin
      minOnes <= (minOnes == 4'd9) ? 4'd0 : minOnes + 4'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      minTens <= 4'd0;
    end else if (minTensInc) begin
      minTens <= (minTens == 4'd5) ? 4'd0 : minTens + 4'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hourOnes <= 4'd0;
      hourTens <= 4'd0;
    end else if (hourInc) begin
      if (hourAtTop) begin
        hourOnes <= 4'd0;
        hourTens <= 4'd0;
      end else if (hourOnes == 4'd9) begin
        hourOnes <= 4'd0;
        hourTens <= hourTens + 4'd1;
      end else begin
        hourOnes <= hourOnes + 4'd1;
      end
    end
  end

  always_comb begin
    case (digitSel)
      2'd0:    shownDigit = minOnes;
      2'd1:    shownDigit = minTens;
      2'd2:    shownDigit = hourOnes;
      default: shownDigit = hourTens;
    endcase
  end

  assign anodeN = ~(4'b0001 << digitSel);
  assign segN   = segPattern(shownDigit);

  p_min_ones_range_r7: assert property (@(posedge clk) disable iff (rst)
    minOnes <= 4'd9);

  p_min_tens_range_r8: assert property (@(posedge clk) disable iff (rst)
    minTens <= 4'd5);

  p_hour_range_r9: assert property (@(posedge clk) disable iff (rst)
    (hourTens <= 4'd2) && ((hourTens != 4'd2) || (hourOnes <= 4'd3)));

  p_set_no_carry_r8: assert property (@(posedge clk) disable iff (rst)
    (strobes.setMinTens && !minOnesCarry && !strobes.setHour) |=> $stable(hourOnes) && $stable(hourTens));

  p_ones_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (strobes.setMinOnes && !secCarry && !strobes.setMinTens && minOnes == 4'd9)
      |=> (minOnes == 4'd0) && $stable(minTens));

  p_day_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (hourInc && hourAtTop) |=> (hourTens == 4'd0) && (hourOnes == 4'd0));

  p_one_anode_r11: assert property (@(posedge clk) disable iff (rst)
    $countones(~anodeN) == 1);

endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int SEC_HALF_COUNT = 50_000_000,
  parameter int SCAN_COUNT     = 100_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       btnMinOnes,
  input  logic       btnMinTens,
  input  logic       btnHour,
  output logic [3:0] anodeN,
  output logic [6:0] segN,
  output logic       secLed
);

  todStrobes_t strobes;
  logic [1:0]  digitSel;

  tod_control #(
    .SEC_HALF_COUNT(SEC_HALF_COUNT),
    .SCAN_COUNT    (SCAN_COUNT),
    .NUM_BTN       (3)
  ) u_control (
    .clk     (clk),
    .rst     (rst),
    .btnRaw  ({btnHour, btnMinTens, btnMinOnes}),
    .strobes (strobes),
    .digitSel(digitSel),
    .secLed  (secLed)
  );

  tod_datapath u_datapath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .digitSel(digitSel),
    .anodeN  (anodeN),
    .segN    (segN)
  );

endmodule

// File: tb/tb_tod_clock.sv
`timescale 1ns/1ps
module tb_tod_clock;

  localparam int HALF = 50;
  localparam int SCAN = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btnMinOnes = 1'b0;
  logic btnMinTens = 1'b0;
  logic btnHour = 1'b0;
  logic [3:0] anodeN;
  logic [6:0] segN;
  logic secLed;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 1'b0;
  bit busy = 1'b0;

  typedef struct {
    string tag;
    int    hh;
    int    mm;
  } expItem_t;

  expItem_t expQ[$];

  always #2 clk = ~clk;

  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  tod_clock #(.SEC_HALF_COUNT(HALF), .SCAN_COUNT(SCAN)) dut (
    .clk(clk), .rst(rst),
    .btnMinOnes(btnMinOnes), .btnMinTens(btnMinTens), .btnHour(btnHour),
    .anodeN(anodeN), .segN(segN), .secLed(secLed)
  );

  function automatic int decodeSeg(input logic [6:0] s);
    case (s)
      7'h40: return 0;  7'h79: return 1;  7'h24: return 2;  7'h30: return 3;
      7'h19: return 4;  7'h12: return 5;  7'h02: return 6;  7'h78: return 7;
      7'h00: return 8;  7'h10: return 9;
      default: return -1;
    endcase
  endfunction

  task automatic report(input string tag, input bit ok, input string detail);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, detail);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Monitor: reads the scanned display and compares it with queued expectations
  initial begin
    forever begin
      expItem_t item;
      int digit[4];
      bit anodeOk;
      int hh;
      int mm;
      wait (expQ.size() > 0);
      busy = 1'b1;
      item = expQ.pop_front();
      for (int p = 0; p < 4; p++) digit[p] = -1;
      anodeOk = 1'b1;
      for (int k = 0; k < 8 * SCAN; k++) begin
        @(negedge clk);
        if ($countones(~anodeN) != 1) anodeOk = 1'b0;
        for (int p = 0; p < 4; p++)
          if (anodeN[p] == 1'b0) digit[p] = decodeSeg(segN);
      end
      report("R11", anodeOk, "more or fewer than one anode low during scan");
      if (digit[0] < 0 || digit[1] < 0 || digit[2] < 0 || digit[3] < 0) begin
        report({item.tag, "/R12"}, 1'b0,
               $sformatf("undecodable digits act=%0d,%0d,%0d,%0d exp=%02d:%02d",
                         digit[3], digit[2], digit[1], digit[0], item.hh, item.mm));
      end else begin
        hh = digit[3] * 10 + digit[2];
        mm = digit[1] * 10 + digit[0];
        report(item.tag, (hh == item.hh) && (mm == item.mm),
               $sformatf("act=%02d:%02d exp=%02d:%02d", hh, mm, item.hh, item.mm));
      end
      busy = 1'b0;
    end
  end

  // Driver side of the scoreboard
  task automatic expectTime(input string tag, input int hh, input int mm);
    expItem_t item;
    item.tag = tag;
    item.hh = hh;
    item.mm = mm;
    expQ.push_back(item);
    @(negedge clk);
    wait (expQ.size() == 0 && !busy);
  endtask

  task automatic press(input int which, input int hold);
    @(negedge clk);
    case (which)
      0: btnMinOnes = 1'b1;
      1: btnMinTens = 1'b1;
      default: btnHour = 1'b1;
    endcase
    repeat (hold) @(negedge clk);
    btnMinOnes = 1'b0;
    btnMinTens = 1'b0;
    btnHour = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic pressN(input int which, input int n);
    for (int i = 0; i < n; i++) press(which, 3);
  endtask

  task automatic waitCycle(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  initial begin
    #600_000;
    report("watchdog", 1'b0, "act=timeout exp=completion");
    finishRun();
  end

  initial begin
    int toggles;
    logic lastLed;
    repeat (4) @(negedge clk);
    report("R1", (secLed == 1'b0), $sformatf("secLed during reset act=%0b exp=0", secLed));
    rst = 1'b0;
    @(negedge clk);
    report("R1", (secLed == 1'b0), $sformatf("secLed after reset act=%0b exp=0", secLed));
    expectTime("R1", 0, 0);

    // R2: toggle rate of the seconds LED over 20 half-periods
    toggles = 0;
    lastLed = secLed;
    for (int k = 0; k < 20 * HALF; k++) begin
      @(negedge clk);
      if (secLed != lastLed) toggles++;
      lastLed = secLed;
    end
    report("R2", toggles == 20, $sformatf("toggles act=%0d exp=20", toggles));

    pressN(0, 3);
    expectTime("R7", 0, 3);
    pressN(1, 2);
    expectTime("R8", 0, 23);
    pressN(2, 5);
    expectTime("R9", 5, 23);
    pressN(0, 7);
    expectTime("R7", 5, 20);
    pressN(1, 4);
    expectTime("R8", 5, 0);
    pressN(2, 18);
    expectTime("R9", 23, 0);
    pressN(2, 1);
    expectTime("R9", 0, 0);
    press(0, 30);
    expectTime("R10", 0, 1);
    press(2, 30);
    expectTime("R10", 1, 1);
    pressN(2, 22);
    pressN(1, 5);
    pressN(0, 8);
    expectTime("R9", 23, 59);

    waitCycle(6100);
    expectTime("R6", 0, 0);
    waitCycle(12100);
    expectTime("R3", 0, 1);
    waitCycle(60100);
    expectTime("R3", 0, 9);
    waitCycle(66100);
    expectTime("R4", 0, 10);
    pressN(1, 4);
    pressN(0, 9);
    expectTime("R8", 0, 59);
    waitCycle(72100);
    expectTime("R5", 1, 0);
    finishRun();
  end

endmodule